// File: doc/BRIEF.md
# Filter Output Mode Mixer

This block is the final output stage of a sound generator's state-variable filter. Each sample strobe, it takes the three filter states (high-pass, band-pass and low-pass), the sum of the voices that bypass the filter, and the current mode and volume settings. It then produces one registered signed sample.

A 3-bit mode field chooses which filter states join the mix. Any combination is allowed, and the chosen states are added with equal weight. The bypass sum and a fixed negative DC offset of -454 are added to the filtered sum. The total is then multiplied by a 4-bit master volume.

A filter-enable input set low removes the filtered contribution entirely. The output then carries only the bypass sum plus the offset, scaled by the volume. The result register changes only on a strobe and holds its value between strobes.

Top module: `filt_out_mixer`

## Requirements
- R1: While rst_ni is low, and after reset until the first strobe, sample_o is 0.
- R2: Mode bit 0 set adds lp_i to the filtered sum.
- R3: Mode bit 1 set adds bp_i to the filtered sum.
- R4: Mode bit 2 set adds hp_i to the filtered sum.
- R5: Mode 0 adds no filtered signal, and any combination of mode bits adds the selected states with weight 1 each.
- R6: The constant -454 is added to bypass plus filtered sum before the multiply, so zero inputs at volume v give -454*v.
- R7: Volume 0 gives sample_o = 0 for any inputs and mode.
- R8: With filt_en_i low, sample_o = (bypass_i - 454) * vol_i regardless of mode_i, hp_i, bp_i and lp_i.
- R9: sample_o takes the result for the inputs present in a cycle with strobe_i high at that clock edge, and is unchanged in cycles with strobe_i low.
- R10: The full signed range is kept without wrap: all three states and bypass at -2^23 with mode 7 and volume 15 give (-4*2^23 - 454)*15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Sample strobe; result registered when high |
| filt_en_i | input | 1 | High: filtered paths mixed in; low: filter ignored |
| mode_i | input | 3 | Bit 0 low-pass, bit 1 band-pass, bit 2 high-pass |
| vol_i | input | 4 | Master volume, unsigned 0..15 |
| hp_i | input | 24 | High-pass state, signed |
| bp_i | input | 24 | Band-pass state, signed |
| lp_i | input | 24 | Low-pass state, signed |
| bypass_i | input | 24 | Sum of unfiltered voices, signed |
| sample_o | output | 36 | Mixed, scaled sample, signed |

## Verification
Mode selection and volume scaling act on the same strobe. Volume 0 must mask whatever mode picks, and filt_en_i low must override a full mode 7 selection. The bench drives these together: mode 7 with volume 0, mode 7 with the filter disabled, and mode 7 with volume 15 at negative full scale. Each result is judged against a scoreboard value computed from the mixing equation. Back-to-back strobes that change mode and volume together check that neither setting leaks into the neighbouring sample.

// File: rtl/mixer_pkg.sv
package mixer_pkg;
  localparam int DATA_W = 24;
  localparam int OUT_W  = 36;
  localparam int VOL_W  = 4;
  localparam int MODE_W = 3;
  // mode bit positions decoded by the selector
  localparam int MODE_LP = 0;
  localparam int MODE_BP = 1;
  localparam int MODE_HP = 2;
  // fixed mixer offset, truncating divide then arithmetic shift: -454
  localparam int MIX_DC = (-4095 * 255 / 18) >>> 7;
endpackage

// File: rtl/filt_tap_sel.sv
module filt_tap_sel
  import mixer_pkg::*;
#(
  parameter int IN_W  = DATA_W,
  parameter int SUM_W = IN_W + 2
) (
  input  logic                    en_i,
  input  logic [MODE_W-1:0]       mode_i,
  input  logic signed [IN_W-1:0]  hp_i,
  input  logic signed [IN_W-1:0]  bp_i,
  input  logic signed [IN_W-1:0]  lp_i,
  output logic signed [SUM_W-1:0] sum_o
);
  logic signed [SUM_W-1:0] tap [MODE_W];

  assign tap[MODE_LP] = SUM_W'(lp_i);
  assign tap[MODE_BP] = SUM_W'(bp_i);
  assign tap[MODE_HP] = SUM_W'(hp_i);

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < MODE_W; i++)
      if (en_i && mode_i[i]) sum_o = sum_o + tap[i];
  end
endmodule

// File: rtl/mix_scale.sv
module mix_scale
  import mixer_pkg::*;
#(
  parameter int IN_W   = DATA_W,
  parameter int FILT_W = IN_W + 2,
  parameter int OW     = OUT_W,
  parameter int TOT_W  = FILT_W + 1,
  parameter int PROD_W = TOT_W + VOL_W + 1
) (
  input  logic signed [IN_W-1:0]   bypass_i,
  input  logic signed [FILT_W-1:0] filt_i,
  input  logic [VOL_W-1:0]         vol_i,
  output logic signed [OW-1:0]     prod_o
);
  logic signed [TOT_W-1:0]  tot;
  logic signed [PROD_W-1:0] prod;
  logic signed [VOL_W:0]    vol_s;

  assign tot   = TOT_W'(bypass_i) + TOT_W'(filt_i) + TOT_W'(MIX_DC);
  assign vol_s = $signed({1'b0, vol_i});
  assign prod  = PROD_W'(tot) * PROD_W'(vol_s);
  assign prod_o = OW'(prod);

  initial begin
    // product must fit the output width
    prod_width_chk: assert (OW >= PROD_W);
  end
endmodule

// File: rtl/filt_out_mixer.sv
module filt_out_mixer
  import mixer_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     strobe_i,
  input  logic                     filt_en_i,
  input  logic [MODE_W-1:0]        mode_i,
  input  logic [VOL_W-1:0]         vol_i,
  input  logic signed [DATA_W-1:0] hp_i,
  input  logic signed [DATA_W-1:0] bp_i,
  input  logic signed [DATA_W-1:0] lp_i,
  input  logic signed [DATA_W-1:0] bypass_i,
  output logic signed [OUT_W-1:0]  sample_o
);
  localparam int FILT_W = DATA_W + 2;

  logic signed [FILT_W-1:0] filt_sum;
  logic signed [OUT_W-1:0]  mix_val;

  filt_tap_sel #(.IN_W(DATA_W), .SUM_W(FILT_W)) u_sel (
    .en_i   (filt_en_i),
    .mode_i (mode_i),
    .hp_i   (hp_i),
    .bp_i   (bp_i),
    .lp_i   (lp_i),
    .sum_o  (filt_sum)
  );

  mix_scale #(.IN_W(DATA_W), .FILT_W(FILT_W), .OW(OUT_W)) u_scale (
    .bypass_i (bypass_i),
    .filt_i   (filt_sum),
    .vol_i    (vol_i),
    .prod_o   (mix_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sample_o <= '0;
    else if (strobe_i) sample_o <= mix_val;
  end

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(sample_o));

  // R7
  mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && vol_i == '0) |=> sample_o == '0);

  // R8
  bypass_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !filt_en_i) |=>
      longint'(sample_o) == (longint'($past(bypass_i)) - 454) * longint'($past(vol_i)));

  // R5
  mode_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && mode_i == '0 && vol_i == 4'd1) |=>
      longint'(sample_o) == longint'($past(bypass_i)) - 454);
endmodule

// File: tb/tb_filt_out_mixer.sv
module tb_filt_out_mixer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic en = 1'b1;
  logic [2:0] mode = '0;
  logic [3:0] vol = '0;
  logic signed [23:0] hp = '0, bp = '0, lp = '0, byp = '0;
  logic signed [35:0] sample;

  int checks = 0;
  int errors = 0;
  longint exp_q[$];
  string  tag_q[$];

  always #10 clk = ~clk;

  filt_out_mixer dut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .filt_en_i(en),
    .mode_i(mode), .vol_i(vol), .hp_i(hp), .bp_i(bp), .lp_i(lp),
    .bypass_i(byp), .sample_o(sample)
  );

  function automatic longint model(logic e, logic [2:0] m, logic [3:0] v,
                                   longint h, longint b, longint l, longint y);
    longint f = 0;
    if (e) begin
      if (m[0]) f += l;
      if (m[1]) f += b;
      if (m[2]) f += h;
    end
    return (y + f - 454) * longint'(v);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one strobed sample; inputs change at negedge
  task automatic drive(string tag, logic e, logic [2:0] m, logic [3:0] v,
                       longint h, longint b, longint l, longint y);
    @(negedge clk);
    en = e; mode = m; vol = v;
    hp = 24'(h); bp = 24'(b); lp = 24'(l); byp = 24'(y);
    strobe = 1'b1;
    exp_q.push_back(model(e, m, v, h, b, l, y));
    tag_q.push_back(tag);
    @(negedge clk);
    strobe = 1'b0;
  endtask

  // monitor: a strobe at an edge yields the result by the next negedge
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && strobe) begin
        @(negedge clk);
        if (exp_q.size() > 0) begin
          automatic longint e = exp_q.pop_front();
          automatic string  t = tag_q.pop_front();
          check(t, longint'(sample), e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    longint held;
    // R1 during and after reset
    repeat (3) @(negedge clk);
    check("R1 in reset", longint'(sample), 0);
    rst_n = 1'b1;
    @(negedge clk);
    vol = 4'd9; byp = 24'sd1000; mode = 3'd7; hp = 24'sd5;
    repeat (2) @(negedge clk);
    check("R1 after reset", longint'(sample), 0);

    drive("R2 lp only",   1, 3'b001, 4'd3, 1000, 2000, 300, 50);
    drive("R3 bp only",   1, 3'b010, 4'd5, 1000, -2000, 300, 50);
    drive("R4 hp only",   1, 3'b100, 4'd7, -1234, 2000, 300, 50);
    drive("R5 mode 0",    1, 3'b000, 4'd1, 7777, 8888, 9999, 600);
    drive("R5 lp+bp",     1, 3'b011, 4'd2, 11, 22, 33, 44);
    drive("R5 lp+hp",     1, 3'b101, 4'd4, 100, 200, 300, -400);
    drive("R5 bp+hp",     1, 3'b110, 4'd6, 100, 200, 300, -400);
    drive("R5 all",       1, 3'b111, 4'd15, -100, 250, 4000, 0);
    drive("R6 dc only",   1, 3'b111, 4'd1, 0, 0, 0, 0);
    drive("R6 dc vol11",  1, 3'b000, 4'd11, 0, 0, 0, 0);
    drive("R7 vol zero",  1, 3'b111, 4'd0, 8000000, 8000000, 8000000, 8000000);
    drive("R8 disabled",  0, 3'b111, 4'd12, 5000, 6000, 7000, -321);
    drive("R8 dis mode0", 0, 3'b000, 4'd3, -5000, 60, 70, 1321);
    drive("R10 neg full", 1, 3'b111, 4'd15, -8388608, -8388608, -8388608, -8388608);
    drive("R10 pos full", 1, 3'b111, 4'd15, 8388607, 8388607, 8388607, 8388607);

    // R9 hold: change every input without a strobe
    @(negedge clk);
    held = longint'(sample);
    en = 1; mode = 3'b010; vol = 4'd1; bp = 24'sd42; byp = 24'sd1;
    repeat (4) @(negedge clk);
    check("R9 held", longint'(sample), held);
    check("R9 held value", held, model(1, 3'b111, 4'd15, 8388607, 8388607, 8388607, 8388607));

    // R9 back-to-back strobes
    @(negedge clk);
    en = 1; mode = 3'b001; vol = 4'd2; lp = 24'sd10; bp = 24'sd0; hp = 24'sd0; byp = 24'sd0;
    strobe = 1'b1;
    exp_q.push_back(model(1, 3'b001, 4'd2, 0, 0, 10, 0)); tag_q.push_back("R9 b2b first");
    @(negedge clk);
    mode = 3'b100; vol = 4'd0; hp = 24'sd99;
    exp_q.push_back(model(1, 3'b100, 4'd0, 99, 0, 10, 0)); tag_q.push_back("R9 b2b second");
    @(negedge clk);
    strobe = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 queue drained", longint'(exp_q.size()), 0);
    finish_run();
  end
endmodule